// File: doc/BRIEF.md
# Host Mailbox and Interrupt Controller

This block sits between a byte-addressed host register port and an embedded board controller. Two single-byte mailbox ports carry commands and responses. The host posts a command byte. The board takes it and later posts a response byte. Each direction also has a four-byte data area for arguments that travel with the command or the response.

The block also gathers six event sources and the command-response event into a pending map. Each pending bit latches whether or not its source is enabled. The host enable mask gates only the interrupt line, which is active low. The command-response event cannot be masked. A status byte reports whether the host-to-board mailbox is full, whether response data is waiting, whether line driving is enabled, and whether the line is asserted.

Top module: `hostmbx_irq_ctrl`

## Requirements
- R1: After reset, every register reads 00h, `board_cmd_full` is 0 and `irq_n` is 1.
- R2: A host write to offset 2Fh while the command mailbox is empty stores the byte on `board_cmd_byte` and sets `board_cmd_full`. A pulse on `board_cmd_take` empties the mailbox. A host write to 2Fh while the mailbox is full is dropped, and the byte stays unchanged.
- R3: Offsets 20h..23h are host read/write. Offset 20h+n holds bits 8n+7..8n of `board_cmd_data`.
- R4: A `board_post` pulse loads the response byte, which is read at offset 0Fh. It loads the response data, read at offset 1Ch+n as bits 8n+7..8n. It also sets the data-ready flag and bit 7 of the pending map at 0Eh.
- R5: A host read of 0Fh returns the response byte and clears the data-ready flag and pending bit 7 at the next edge. A `board_post` in the same cycle wins, and both stay set.
- R6: A pulse on `evt_pulse[i]` (i = 0..5) sets pending bit i whatever the enables are. A pulse on `evt_clear[i]` clears it. A set and a clear in the same cycle leave the bit set.
- R7: Bits 5..0 of the enable register at 2Eh are read/write. Bits 7..6 of 2Eh and bit 6 of 0Eh always read 0.
- R8: `irq_n` is registered. It goes to 0 one cycle after `irq_drive_en` is 1 and either pending bit 7 is set or some pending bit i (0..5) has enable bit i set. Otherwise it returns to 1.
- R9: Offset FEh reads bit 4 = `irq_drive_en`, bit 2 = command mailbox full, bit 1 = `irq_n` is low, bit 0 = response data ready. All other bits read 0.
- R10: Unmapped offsets read 00h. Host writes to read-only or unmapped offsets (0Eh, 0Fh, 1Ch..1Fh, FEh and others) change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (side effects at 0Fh only) |
| host_addr | input | 8 | Host byte offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte for `host_addr`, combinational |
| board_cmd_take | input | 1 | Board has consumed the command byte |
| board_cmd_full | output | 1 | Command mailbox holds an unread byte |
| board_cmd_byte | output | 8 | Command byte |
| board_cmd_data | output | 32 | Command data area |
| board_post | input | 1 | Board posts a response |
| board_post_byte | input | 8 | Response byte to post |
| board_post_data | input | 32 | Response data to post |
| evt_pulse | input | 6 | One-cycle event pulses, one per source |
| evt_clear | input | 6 | Board clears serviced events |
| irq_drive_en | input | 1 | Enables driving of the interrupt line |
| irq_n | output | 1 | Interrupt line, active low |

## Verification
Several input patterns drive the pending and line logic. Events with all enables off show that latching is separate from masking. Events with line driving off, then on, separate the two gating terms. Clearing the events shows that the line is released. A response posted with every enable cleared shows that bit 7 bypasses the mask. Collisions are driven on purpose (set with clear, post with host read, command write while full) to confirm the stated winner of each. Writes to read-only offsets are followed by reads of the same offsets, which shows that they had no effect.

// File: rtl/hmb_pkg.sv
package hmb_pkg;
    localparam int BYTE_W       = 8;
    localparam int ADDR_W       = 8;
    localparam int MBX_BYTES    = 4;
    localparam int MBX_W        = BYTE_W * MBX_BYTES;
    localparam int IDX_W        = $clog2(MBX_BYTES);
    localparam int SRC_N        = 6;
    localparam int PEND_W       = 8;
    localparam int CMD_RESP_BIT = 7;

    localparam logic [ADDR_W-1:0] OFF_PEND      = 8'h0E;
    localparam logic [ADDR_W-1:0] OFF_RESP_PORT = 8'h0F;
    localparam logic [ADDR_W-1:0] OFF_RESP_AREA = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_CMD_AREA  = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_IRQ_EN    = 8'h2E;
    localparam logic [ADDR_W-1:0] OFF_CMD_PORT  = 8'h2F;
    localparam logic [ADDR_W-1:0] OFF_STATUS    = 8'hFE;

    typedef struct packed {
        logic                wr;
        logic                rd;
        logic [ADDR_W-1:0]   addr;
        logic [BYTE_W-1:0]   wdata;
    } host_req_t;

    typedef struct packed {
        logic drv_en;
        logic full;
        logic line_on;
        logic ready;
    } status_t;

    // aligned four-byte window test
    function automatic logic in_area(logic [ADDR_W-1:0] addr, logic [ADDR_W-1:0] base);
        return addr[ADDR_W-1:IDX_W] == base[ADDR_W-1:IDX_W];
    endfunction

    function automatic logic [BYTE_W-1:0] pack_status(status_t s);
        logic [BYTE_W-1:0] b;
        b    = '0;
        b[4] = s.drv_en;
        b[2] = s.full;
        b[1] = s.line_on;
        b[0] = s.ready;
        return b;
    endfunction
endpackage

// File: rtl/hmb_h2b_mbox.sv
module hmb_h2b_mbox
    import hmb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                port_we,
    input  logic                area_we,
    input  logic [IDX_W-1:0]    area_idx,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic                take,
    output logic                full,
    output logic [BYTE_W-1:0]   cmd_byte,
    output logic [MBX_W-1:0]    cmd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full     <= 1'b0;
            cmd_byte <= '0;
        end else if (port_we && !full) begin
            full     <= 1'b1;
            cmd_byte <= wdata;
        end else if (take) begin
            full     <= 1'b0;
        end
    end

    for (genvar g = 0; g < MBX_BYTES; g++) begin : g_area
        always_ff @(posedge clk) begin
            if (rst)
                cmd_data[g*BYTE_W +: BYTE_W] <= '0;
            else if (area_we && area_idx == IDX_W'(g))
                cmd_data[g*BYTE_W +: BYTE_W] <= wdata;
        end
    end
endmodule

// File: rtl/hmb_b2h_mbox.sv
module hmb_b2h_mbox
    import hmb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                post,
    input  logic [BYTE_W-1:0]   post_byte,
    input  logic [MBX_W-1:0]    post_data,
    input  logic                take,
    output logic                ready,
    output logic [BYTE_W-1:0]   resp_byte,
    output logic [MBX_W-1:0]    resp_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ready     <= 1'b0;
            resp_byte <= '0;
            resp_data <= '0;
        end else if (post) begin
            ready     <= 1'b1;
            resp_byte <= post_byte;
            resp_data <= post_data;
        end else if (take) begin
            ready     <= 1'b0;
        end
    end
endmodule

// File: rtl/hmb_irq.sv
module hmb_irq
    import hmb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [SRC_N-1:0]    evt_set,
    input  logic [SRC_N-1:0]    evt_clr,
    input  logic                resp_pend,
    input  logic                en_we,
    input  logic [SRC_N-1:0]    en_wdata,
    input  logic                drive_en,
    output logic [PEND_W-1:0]   pend,
    output logic [SRC_N-1:0]    en,
    output logic                irq_n
);
    logic [SRC_N-1:0] src_q;
    logic             want;

    for (genvar g = 0; g < SRC_N; g++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst)             src_q[g] <= 1'b0;
            else if (evt_set[g]) src_q[g] <= 1'b1;
            else if (evt_clr[g]) src_q[g] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        en <= '0;
        else if (en_we) en <= en_wdata;
    end

    always_comb begin
        pend                = '0;
        pend[SRC_N-1:0]     = src_q;
        pend[CMD_RESP_BIT]  = resp_pend;
        want                = (|(src_q & en)) | resp_pend;
    end

    always_ff @(posedge clk) begin
        if (rst) irq_n <= 1'b1;
        else     irq_n <= !(drive_en && want);
    end
endmodule

// File: rtl/hostmbx_irq_ctrl.sv
module hostmbx_irq_ctrl
    import hmb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_wr,
    input  logic                  host_rd,
    input  logic [ADDR_W-1:0]     host_addr,
    input  logic [BYTE_W-1:0]     host_wdata,
    output logic [BYTE_W-1:0]     host_rdata,
    input  logic                  board_cmd_take,
    output logic                  board_cmd_full,
    output logic [BYTE_W-1:0]     board_cmd_byte,
    output logic [MBX_W-1:0]      board_cmd_data,
    input  logic                  board_post,
    input  logic [BYTE_W-1:0]     board_post_byte,
    input  logic [MBX_W-1:0]      board_post_data,
    input  logic [SRC_N-1:0]      evt_pulse,
    input  logic [SRC_N-1:0]      evt_clear,
    input  logic                  irq_drive_en,
    output logic                  irq_n
);
    host_req_t          req;
    logic [IDX_W-1:0]   idx;
    logic               in_cmd_area, in_resp_area;
    logic               resp_ready;
    logic [BYTE_W-1:0]  resp_byte;
    logic [MBX_W-1:0]   resp_data;
    logic [PEND_W-1:0]  pend_map;
    logic [SRC_N-1:0]   en_mask;
    logic [BYTE_W-1:0]  resp_bytes [MBX_BYTES];
    logic [BYTE_W-1:0]  cmd_bytes  [MBX_BYTES];
    status_t            st;

    assign req          = '{wr: host_wr, rd: host_rd, addr: host_addr, wdata: host_wdata};
    assign idx          = req.addr[IDX_W-1:0];
    assign in_cmd_area  = in_area(req.addr, OFF_CMD_AREA);
    assign in_resp_area = in_area(req.addr, OFF_RESP_AREA);

    hmb_h2b_mbox u_h2b (
        .clk      (clk),
        .rst      (rst),
        .port_we  (req.wr && req.addr == OFF_CMD_PORT),
        .area_we  (req.wr && in_cmd_area),
        .area_idx (idx),
        .wdata    (req.wdata),
        .take     (board_cmd_take),
        .full     (board_cmd_full),
        .cmd_byte (board_cmd_byte),
        .cmd_data (board_cmd_data)
    );

    hmb_b2h_mbox u_b2h (
        .clk       (clk),
        .rst       (rst),
        .post      (board_post),
        .post_byte (board_post_byte),
        .post_data (board_post_data),
        .take      (req.rd && req.addr == OFF_RESP_PORT),
        .ready     (resp_ready),
        .resp_byte (resp_byte),
        .resp_data (resp_data)
    );

    hmb_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .evt_set   (evt_pulse),
        .evt_clr   (evt_clear),
        .resp_pend (resp_ready),
        .en_we     (req.wr && req.addr == OFF_IRQ_EN),
        .en_wdata  (req.wdata[SRC_N-1:0]),
        .drive_en  (irq_drive_en),
        .pend      (pend_map),
        .en        (en_mask),
        .irq_n     (irq_n)
    );

    for (genvar g = 0; g < MBX_BYTES; g++) begin : g_split
        assign resp_bytes[g] = resp_data[g*BYTE_W +: BYTE_W];
        assign cmd_bytes[g]  = board_cmd_data[g*BYTE_W +: BYTE_W];
    end

    assign st = '{drv_en: irq_drive_en, full: board_cmd_full, line_on: !irq_n, ready: resp_ready};

    always_comb begin
        host_rdata = '0;
        if (in_resp_area)
            host_rdata = resp_bytes[idx];
        else if (in_cmd_area)
            host_rdata = cmd_bytes[idx];
        else begin
            case (req.addr)
                OFF_PEND:      host_rdata = pend_map;
                OFF_RESP_PORT: host_rdata = resp_byte;
                OFF_IRQ_EN:    host_rdata = BYTE_W'(en_mask);
                OFF_CMD_PORT:  host_rdata = board_cmd_byte;
                OFF_STATUS:    host_rdata = pack_status(st);
                default:       host_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/hmb_ctrl_checker.sv
module hmb_ctrl_checker
    import hmb_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                host_wr,
    input logic                host_rd,
    input logic [ADDR_W-1:0]   host_addr,
    input logic [BYTE_W-1:0]   host_rdata,
    input logic                board_cmd_take,
    input logic                board_cmd_full,
    input logic [BYTE_W-1:0]   board_cmd_byte,
    input logic                board_post,
    input logic [SRC_N-1:0]    evt_pulse,
    input logic                irq_drive_en,
    input logic                irq_n,
    input logic                resp_ready,
    input logic [PEND_W-1:0]   pend
);
    assert_full_drop_R2: assert property (@(posedge clk) disable iff (rst)
        (board_cmd_full && host_wr && host_addr == OFF_CMD_PORT) |=> $stable(board_cmd_byte));

    assert_take_empties_R2: assert property (@(posedge clk) disable iff (rst)
        (board_cmd_take && !(host_wr && host_addr == OFF_CMD_PORT)) |=> !board_cmd_full);

    assert_post_ready_R4: assert property (@(posedge clk) disable iff (rst)
        board_post |=> (resp_ready && pend[CMD_RESP_BIT]));

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_addr == OFF_RESP_PORT && !board_post) |=> !pend[CMD_RESP_BIT]);

    assert_evt_latch_R6: assert property (@(posedge clk) disable iff (rst)
        (evt_pulse != '0) |=> ((pend[SRC_N-1:0] & $past(evt_pulse)) == $past(evt_pulse)));

    assert_bit6_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !pend[6]);

    assert_release_R8: assert property (@(posedge clk) disable iff (rst)
        !irq_drive_en |=> irq_n);

    assert_unmaskable_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_drive_en && pend[CMD_RESP_BIT]) |=> !irq_n);

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (host_addr == 8'h40 || host_addr == 8'h10) |-> host_rdata == '0);
endmodule

bind hostmbx_irq_ctrl hmb_ctrl_checker chk_i (
    .clk            (clk),
    .rst            (rst),
    .host_wr        (host_wr),
    .host_rd        (host_rd),
    .host_addr      (host_addr),
    .host_rdata     (host_rdata),
    .board_cmd_take (board_cmd_take),
    .board_cmd_full (board_cmd_full),
    .board_cmd_byte (board_cmd_byte),
    .board_post     (board_post),
    .evt_pulse      (evt_pulse),
    .irq_drive_en   (irq_drive_en),
    .irq_n          (irq_n),
    .resp_ready     (resp_ready),
    .pend           (pend_map)
);

// File: tb/hostmbx_irq_ctrl_tb.sv
module hostmbx_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_addr = '0, host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        board_cmd_take = 1'b0;
    logic        board_cmd_full;
    logic [7:0]  board_cmd_byte;
    logic [31:0] board_cmd_data;
    logic        board_post = 1'b0;
    logic [7:0]  board_post_byte = '0;
    logic [31:0] board_post_data = '0;
    logic [5:0]  evt_pulse = '0, evt_clear = '0;
    logic        irq_drive_en = 1'b0;
    logic        irq_n;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    hostmbx_irq_ctrl dut_i (.*);

    localparam logic [3:0] OP_IDLE = 4'd0, OP_WR = 4'd1, OP_RD = 4'd2, OP_POST = 4'd3,
                           OP_EVT = 4'd4, OP_CLR = 4'd5, OP_DRV = 4'd6, OP_TAKE = 4'd7,
                           OP_IRQ = 4'd8;
    localparam int NV = 48;
    // {req, op, addr, data, expected}
    localparam logic [55:0] VEC [NV] = '{
        {4'd1,  OP_RD,   8'h0F, 32'h0,        8'h00},  // R1
        {4'd1,  OP_RD,   8'hFE, 32'h0,        8'h00},  // R1
        {4'd1,  OP_RD,   8'h0E, 32'h0,        8'h00},  // R1
        {4'd2,  OP_WR,   8'h2F, 32'h5A,       8'h00},  // R2
        {4'd9,  OP_RD,   8'hFE, 32'h0,        8'h04},  // R9
        {4'd2,  OP_WR,   8'h2F, 32'h77,       8'h00},  // R2 dropped
        {4'd2,  OP_RD,   8'h2F, 32'h0,        8'h5A},  // R2
        {4'd2,  OP_TAKE, 8'h00, 32'h0,        8'h00},  // R2
        {4'd2,  OP_RD,   8'hFE, 32'h0,        8'h00},  // R2
        {4'd2,  OP_WR,   8'h2F, 32'h77,       8'h00},  // R2
        {4'd2,  OP_RD,   8'h2F, 32'h0,        8'h77},  // R2
        {4'd3,  OP_WR,   8'h21, 32'hC3,       8'h00},  // R3
        {4'd3,  OP_RD,   8'h21, 32'h0,        8'hC3},  // R3
        {4'd3,  OP_RD,   8'h20, 32'h0,        8'h00},  // R3
        {4'd4,  OP_POST, 8'h9E, 32'h44332211, 8'h00},  // R4
        {4'd4,  OP_RD,   8'h0E, 32'h0,        8'h80},  // R4
        {4'd4,  OP_RD,   8'h1D, 32'h0,        8'h22},  // R4
        {4'd4,  OP_RD,   8'h1F, 32'h0,        8'h44},  // R4
        {4'd9,  OP_RD,   8'hFE, 32'h0,        8'h05},  // R9
        {4'd5,  OP_RD,   8'h0F, 32'h0,        8'h9E},  // R5
        {4'd5,  OP_RD,   8'hFE, 32'h0,        8'h04},  // R5
        {4'd5,  OP_RD,   8'h0E, 32'h0,        8'h00},  // R5
        {4'd6,  OP_EVT,  8'h00, 32'h21,       8'h00},  // R6
        {4'd6,  OP_RD,   8'h0E, 32'h0,        8'h21},  // R6 latched while disabled
        {4'd8,  OP_IRQ,  8'h00, 32'h0,        8'h01},  // R8
        {4'd8,  OP_DRV,  8'h00, 32'h1,        8'h00},  // R8
        {4'd8,  OP_IRQ,  8'h00, 32'h0,        8'h01},  // R8 masked
        {4'd7,  OP_WR,   8'h2E, 32'hFF,       8'h00},  // R7
        {4'd7,  OP_RD,   8'h2E, 32'h0,        8'h3F},  // R7
        {4'd8,  OP_IRQ,  8'h00, 32'h0,        8'h00},  // R8
        {4'd9,  OP_RD,   8'hFE, 32'h0,        8'h16},  // R9
        {4'd6,  OP_CLR,  8'h00, 32'h21,       8'h00},  // R6
        {4'd6,  OP_RD,   8'h0E, 32'h0,        8'h00},  // R6
        {4'd8,  OP_IRQ,  8'h00, 32'h0,        8'h01},  // R8
        {4'd7,  OP_WR,   8'h2E, 32'h00,       8'h00},  // R7
        {4'd8,  OP_POST, 8'h01, 32'h0,        8'h00},  // R8
        {4'd8,  OP_IDLE, 8'h00, 32'h0,        8'h00},  // R8
        {4'd8,  OP_IRQ,  8'h00, 32'h0,        8'h00},  // R8 unmaskable
        {4'd5,  OP_RD,   8'h0F, 32'h0,        8'h01},  // R5
        {4'd8,  OP_IDLE, 8'h00, 32'h0,        8'h00},  // R8
        {4'd8,  OP_IRQ,  8'h00, 32'h0,        8'h01},  // R8
        {4'd10, OP_WR,   8'h0E, 32'hFF,       8'h00},  // R10
        {4'd10, OP_WR,   8'hFE, 32'hFF,       8'h00},  // R10
        {4'd10, OP_RD,   8'h0E, 32'h0,        8'h00},  // R10
        {4'd10, OP_RD,   8'h40, 32'h0,        8'h00},  // R10
        {4'd10, OP_WR,   8'h1C, 32'hAA,       8'h00},  // R10
        {4'd10, OP_RD,   8'h1C, 32'h0,        8'h00},  // R10
        {4'd10, OP_RD,   8'h10, 32'h0,        8'h00}   // R10
    };

    task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic idle_inputs();
        host_wr = 1'b0; host_rd = 1'b0; board_cmd_take = 1'b0; board_post = 1'b0;
        evt_pulse = '0; evt_clear = '0;
    endtask

    task automatic host_read(input int req, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        idle_inputs();
        host_addr = a; host_rd = 1'b1;
        #1 check(req, 32'(host_rdata), 32'(exp), "read");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(1, 32'(irq_n), 32'd1, "irq_n in reset");     // R1
        check(1, 32'(board_cmd_full), 32'd0, "full in reset");
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            logic [3:0]  rq, op;
            logic [7:0]  ad, ex;
            logic [31:0] dt;
            {rq, op, ad, dt, ex} = VEC[i];
            @(negedge clk);
            idle_inputs();
            host_addr = ad;
            case (op)
                OP_WR:   begin host_wr = 1'b1; host_wdata = dt[7:0]; end
                OP_RD:   host_rd = 1'b1;
                OP_POST: begin board_post = 1'b1; board_post_byte = ad; board_post_data = dt; end
                OP_EVT:  evt_pulse = dt[5:0];
                OP_CLR:  evt_clear = dt[5:0];
                OP_DRV:  irq_drive_en = dt[0];
                OP_TAKE: board_cmd_take = 1'b1;
                default: ;
            endcase
            #1;
            if (op == OP_RD)  check(int'(rq), 32'(host_rdata), 32'(ex), "vector read");
            if (op == OP_IRQ) check(int'(rq), 32'(irq_n), 32'(ex[0]), "vector irq_n");
        end

        // board-side view of the command mailbox
        @(negedge clk); idle_inputs();
        check(2, 32'(board_cmd_byte), 32'h77, "cmd byte");        // R2
        check(2, 32'(board_cmd_full), 32'd1, "cmd full");         // R2
        check(3, board_cmd_data, 32'h0000C300, "cmd data");       // R3

        // set and clear together: set wins
        @(negedge clk); idle_inputs();
        evt_pulse = 6'h02; evt_clear = 6'h02;
        host_read(6, 8'h0E, 8'h02);                               // R6
        @(negedge clk); idle_inputs(); evt_clear = 6'h02;
        host_read(6, 8'h0E, 8'h00);                               // R6

        // post and host read of the response port together: post wins
        @(negedge clk); idle_inputs();
        board_post = 1'b1; board_post_byte = 8'h05; host_addr = 8'h0F; host_rd = 1'b1;
        @(negedge clk); idle_inputs();
        host_addr = 8'h0E;
        #1 check(5, 32'(host_rdata), 32'h80, "post beats read pend"); // R5
        host_read(5, 8'h0F, 8'h05);                               // R5

        // reset mid-run restores everything
        @(negedge clk); idle_inputs(); irq_drive_en = 1'b0; rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1 check(1, 32'(irq_n), 32'd1, "irq_n after reset");      // R1
        check(1, 32'(board_cmd_full), 32'd0, "full after reset"); // R1
        host_read(1, 8'h0E, 8'h00);                               // R1
        host_read(1, 8'hFE, 8'h00);                               // R1
        host_read(1, 8'h2F, 8'h00);                               // R1

        @(negedge clk); idle_inputs();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule